// File: doc/BRIEF.md
# Two-Wire Bus Start, Repeated-Start and Stop Generator

This block produces the framing conditions of a two-wire serial bus: a start, a repeated start, or a stop. Software asks for a condition by pulsing one of three request inputs, which sets a pending bit. It then raises an output-select input, which moves the bus pins from the ordinary serial data path to this block's sequencer. The sequencer then plays out the clock and data edges of the highest-priority pending condition, with timed setup and hold intervals.

Both pin outputs are drive-low enables for open-drain pads. A 1 pulls the line low and a 0 releases it. When a condition finishes, its pending bit clears and a one-cycle done pulse is raised. The pins then hold the final levels for as long as output-select stays high. Data shifting, clock stretching, arbitration and condition detection are handled elsewhere.

Top module: `i2c_cond_gen`

## Requirements
- R1: A one-cycle pulse on `wr_start`, `wr_restart` or `wr_stop` sets the pending bit `pend[0]`, `pend[1]` or `pend[2]` respectively. The bit is visible in the following cycle and stays set until its own condition completes.
- R2: While `out_sel` is 0, `scl_lo` equals `ser_scl_lo` and `sda_lo` equals `ser_sda_lo`, and no pending request starts a condition.
- R3: A condition begins only in the cycle after `out_sel` is sampled going from 0 to 1 while a request is pending. A request written while `out_sel` is already 1 stays pending and leaves the pins unchanged until `out_sel` falls and rises again.
- R4: When several requests are pending, one select rise serves exactly one of them, in the order stop, then restart, then start. The others remain pending.
- R5: A start drives SDA low with SCL released for HOLD_CYC cycles, then drives both low.
- R6: A repeated start drives SCL low with SDA released for SETUP_CYC cycles. It then releases both for SETUP_CYC cycles, drives SDA low with SCL released for HOLD_CYC cycles, and then drives both low.
- R7: A stop drives both low for SETUP_CYC cycles, then releases SCL with SDA low for SETUP_CYC cycles, then releases both.
- R8: In the first cycle of the final levels, `done` is 1 for exactly one cycle, and the served pending bit reads 0 in that same cycle.
- R9: After a condition completes and while `out_sel` stays 1, the pins keep the condition's final levels.
- R10: After reset, `pend` is 0 and `done` is 0. With `out_sel` at 1 and no request pending, both pins are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | Write-1 pulse arming a start |
| wr_restart | input | 1 | Write-1 pulse arming a repeated start |
| wr_stop | input | 1 | Write-1 pulse arming a stop |
| out_sel | input | 1 | 1 hands the pins to the condition sequencer |
| ser_scl_lo | input | 1 | SCL drive-low from the serial data path |
| ser_sda_lo | input | 1 | SDA drive-low from the serial data path |
| scl_lo | output | 1 | SCL pad drive-low enable |
| sda_lo | output | 1 | SDA pad drive-low enable |
| pend | output | 3 | Pending requests: bit 2 stop, bit 1 restart, bit 0 start |
| done | output | 1 | One-cycle pulse when a condition completes |

## Verification
If the phase register or the interval counter is corrupted, the very next cycle shows a wrong pin pair, or a phase that ends early or late, relative to the per-cycle waveform. The bench therefore compares both pins on every cycle of every condition. If the pending bits are corrupted, the wrong condition is served at the next select rise, or the `pend` value read at `done` is wrong. A broken launch qualifier shows up as pin activity within one cycle of a request that should have stayed pending.

// File: rtl/i2c_cond_pkg.sv
// Shared types for the bus condition generator.
// Assumes: request vectors are ordered {stop, restart, start}.
package i2c_cond_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RS_LOW,
        PH_RS_SETUP,
        PH_ST_HOLD,
        PH_SP_LOW,
        PH_SP_SETUP
    } phase_t;

    localparam int NUM_REQ = 3;
    localparam int KIND_STOP = 2;

    typedef logic [NUM_REQ-1:0] req_vec_t;
endpackage

// File: rtl/i2c_cond_req.sv
// Pending request register with a fixed-priority grant.
// Assumes: set and clear pulses are one cycle; a set in the same cycle as a clear wins.
module i2c_cond_req
    import i2c_cond_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  req_vec_t set_i,
    input  req_vec_t clr_i,
    output req_vec_t pend_o,
    output req_vec_t grant_o
);
    req_vec_t pend_q;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
        // Hold one pending bit: armed by its write pulse, dropped on completion.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= (pend_q[g] & ~clr_i[g]) | set_i[g];
        end
    end

    // Grant the highest pending bit: stop over restart over start.
    always_comb begin
        grant_o = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (pend_q[i] && grant_o == '0) grant_o[i] = 1'b1;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/i2c_cond_timer.sv
// Down-counting interval timer for the condition phases.
// Assumes: a loaded value N gives a phase length of N+1 cycles.
module i2c_cond_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_cond_seq.sv
// Phase sequencer that shapes the SCL/SDA edges of a start, restart or stop.
// Assumes: launch_i comes with exactly one grant bit set; outputs are drive-low enables.
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int HOLD_CYC  = 4,
    parameter int CW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  req_vec_t      grant_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          scl_lo_o,
    output logic          sda_lo_o,
    output logic          busy_o,
    output logic          done_o,
    output req_vec_t      clr_o
);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);

    phase_t   phase_q, phase_d;
    req_vec_t kind_q;
    logic     finish;
    logic     held_scl_q, held_sda_q, done_q;

    // Choose the next phase and the interval to load at each phase change.
    always_comb begin
        phase_d    = phase_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        finish     = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (launch_i) begin
                tmr_load_o = 1'b1;
                if (grant_i[KIND_STOP]) begin
                    phase_d   = PH_SP_LOW;
                    tmr_val_o = SETUP_LD;
                end else if (grant_i[1]) begin
                    phase_d   = PH_RS_LOW;
                    tmr_val_o = SETUP_LD;
                end else begin
                    phase_d   = PH_ST_HOLD;
                    tmr_val_o = HOLD_LD;
                end
            end
            PH_RS_LOW: if (tmr_zero_i) begin
                phase_d    = PH_RS_SETUP;
                tmr_load_o = 1'b1;
                tmr_val_o  = SETUP_LD;
            end
            PH_RS_SETUP: if (tmr_zero_i) begin
                phase_d    = PH_ST_HOLD;
                tmr_load_o = 1'b1;
                tmr_val_o  = HOLD_LD;
            end
            PH_SP_LOW: if (tmr_zero_i) begin
                phase_d    = PH_SP_SETUP;
                tmr_load_o = 1'b1;
                tmr_val_o  = SETUP_LD;
            end
            PH_ST_HOLD, PH_SP_SETUP: if (tmr_zero_i) begin
                phase_d = PH_IDLE;
                finish  = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Register phase, served kind, completion pulse and the resting pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            kind_q     <= '0;
            done_q     <= 1'b0;
            held_scl_q <= 1'b0;
            held_sda_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= finish;
            if (launch_i && phase_q == PH_IDLE) kind_q <= grant_i;
            if (finish) begin
                held_scl_q <= !kind_q[KIND_STOP];
                held_sda_q <= !kind_q[KIND_STOP];
            end
        end
    end

    // Map each phase to its SCL/SDA drive-low pair.
    always_comb begin
        unique case (phase_q)
            PH_RS_LOW:   {scl_lo_o, sda_lo_o} = 2'b10;
            PH_RS_SETUP: {scl_lo_o, sda_lo_o} = 2'b00;
            PH_ST_HOLD:  {scl_lo_o, sda_lo_o} = 2'b01;
            PH_SP_LOW:   {scl_lo_o, sda_lo_o} = 2'b11;
            PH_SP_SETUP: {scl_lo_o, sda_lo_o} = 2'b01;
            default:     {scl_lo_o, sda_lo_o} = {held_scl_q, held_sda_q};
        endcase
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign done_o = done_q;
    assign clr_o  = finish ? kind_q : '0;
endmodule

// File: rtl/i2c_cond_gen.sv
// Top of the bus condition generator: request register, launch qualifier,
// sequencer, interval timer and the pin multiplexer.
// Assumes: out_sel is a software level; the pads are open drain (1 = pull low).
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int HOLD_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_start,
    input  logic       wr_restart,
    input  logic       wr_stop,
    input  logic       out_sel,
    input  logic       ser_scl_lo,
    input  logic       ser_sda_lo,
    output logic       scl_lo,
    output logic       sda_lo,
    output logic [2:0] pend,
    output logic       done
);
    localparam int MAX_CYC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    req_vec_t      grant_w, clr_w, pend_w;
    logic          sel_q, launch, seq_busy, seq_scl, seq_sda;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;

    // Remember the previous select level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= out_sel;
    end

    assign launch = out_sel && !sel_q && (pend_w != '0) && !seq_busy;

    i2c_cond_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   ({wr_stop, wr_restart, wr_start}),
        .clr_i   (clr_w),
        .pend_o  (pend_w),
        .grant_o (grant_w)
    );

    i2c_cond_timer #(.CW(CW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    i2c_cond_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .CW        (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .grant_i    (grant_w),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .scl_lo_o   (seq_scl),
        .sda_lo_o   (seq_sda),
        .busy_o     (seq_busy),
        .done_o     (done),
        .clr_o      (clr_w)
    );

    assign scl_lo = out_sel ? seq_scl : ser_scl_lo;
    assign sda_lo = out_sel ? seq_sda : ser_sda_lo;
    assign pend   = pend_w;
endmodule

// File: rtl/i2c_cond_gen_chk.sv
// Checker for the bus condition generator, bound to its top.
// Assumes: it sees the top's grant and sequencer busy nets.
module i2c_cond_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_start,
    input logic       wr_restart,
    input logic       wr_stop,
    input logic       out_sel,
    input logic       done,
    input logic [2:0] pend,
    input logic [2:0] grant,
    input logic       busy
);
    // R3
    launch_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(out_sel) && $past(pend) != 3'b000));

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R1
    pend_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_start || wr_restart || wr_stop) && !done) |-> $stable(pend));
endmodule

bind i2c_cond_gen i2c_cond_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .wr_restart (wr_restart),
    .wr_stop    (wr_stop),
    .out_sel    (out_sel),
    .done       (done),
    .pend       (pend),
    .grant      (grant_w),
    .busy       (seq_busy)
);

// File: tb/i2c_cond_gen_tb.sv
module i2c_cond_gen_tb_top;
    localparam int S = 4;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0, wr_restart = 1'b0, wr_stop = 1'b0;
    logic       out_sel = 1'b0;
    logic       ser_scl_lo = 1'b0, ser_sda_lo = 1'b0;
    logic       scl_lo, sda_lo, done;
    logic [2:0] pend;

    int         checks = 0;
    int         errors = 0;
    logic [2:0] exp_pend = 3'b000;
    logic [1:0] held = 2'b00;

    always #4 clk = ~clk;

    i2c_cond_gen #(.SETUP_CYC(S), .HOLD_CYC(H)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_restart(wr_restart), .wr_stop(wr_stop),
        .out_sel(out_sel), .ser_scl_lo(ser_scl_lo), .ser_sda_lo(ser_sda_lo),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .pend(pend), .done(done)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {1'b0, done, scl_lo, sda_lo};
    endfunction

    // Pulse the request inputs for one cycle and confirm the pending bits (R1).
    task automatic req(input logic [2:0] m);
        {wr_stop, wr_restart, wr_start} = m;
        @(negedge clk);
        {wr_stop, wr_restart, wr_start} = 3'b000;
        exp_pend = exp_pend | m;
        chk("R1 pending set", {1'b0, pend}, {1'b0, exp_pend});
    endtask

    task automatic step(input string tag, input logic [1:0] lv);
        @(negedge clk);
        chk(tag, pins(), {2'b00, lv});
    endtask

    // Raise select and follow the winning condition cycle by cycle (R4..R9).
    task automatic serve();
        int k;
        logic [1:0] fin;
        k = exp_pend[2] ? 2 : (exp_pend[1] ? 1 : 0);
        ser_scl_lo = 1'b1;
        ser_sda_lo = 1'b0;
        out_sel = 1'b1;
        if (k == 2) begin
            repeat (S) step("R7 stop low phase (R4 priority)", 2'b11);
            repeat (S) step("R7 stop setup phase", 2'b01);
            fin = 2'b00;
        end else if (k == 1) begin
            repeat (S) step("R6 restart scl-low phase (R4 priority)", 2'b10);
            repeat (S) step("R6 restart released phase", 2'b00);
            repeat (H) step("R6 restart hold phase", 2'b01);
            fin = 2'b11;
        end else begin
            repeat (H) step("R5 start hold phase", 2'b01);
            fin = 2'b11;
        end
        @(negedge clk);
        exp_pend[k] = 1'b0;
        chk("R8 done with final levels", pins(), {2'b01, fin});
        chk("R8 served bit cleared, R4 others kept", {1'b0, pend}, {1'b0, exp_pend});
        @(negedge clk);
        chk("R9 final levels held", pins(), {2'b00, fin});
        held = fin;
        out_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset pend/done", {done, pend}, 4'h0);
        out_sel = 1'b1;
        @(negedge clk);
        chk("R10 idle released", pins(), 4'h0);
        out_sel = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 4; i++) begin
            {ser_scl_lo, ser_sda_lo} = 2'(i);
            #1;
            chk("R2 serial path passthrough", pins(), 4'(i));
            @(negedge clk);
        end

        ser_scl_lo = 1'b0;
        ser_sda_lo = 1'b1;
        req(3'b001);
        repeat (6) begin
            @(negedge clk);
            chk("R2 no launch while deselected", pins(), 4'b0001);
        end
        chk("R2 request still pending", {1'b0, pend}, 4'b0001);
        serve();
        @(negedge clk);

        for (int m = 1; m < 8; m++) begin
            req(3'(m));
            while (exp_pend != 3'b000) begin
                serve();
                @(negedge clk);
            end
        end

        out_sel = 1'b1;
        @(negedge clk);
        req(3'b001);
        repeat (6) begin
            @(negedge clk);
            chk("R3 request under held select waits", pins(), {2'b00, held});
        end
        chk("R3 request still pending", {1'b0, pend}, 4'b0001);
        out_sel = 1'b0;
        @(negedge clk);
        serve();
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule